// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter

This block is a small binary counter that steps once per rising clock edge, either upward or downward as a direction input selects. An active-low enable gates the stepping. Two asynchronous controls take priority over the clock. A master clear forces the count to zero. A level-sensitive preset makes the count follow a parallel data word for as long as it is held high. The clear wins over the preset.

An active-low terminal flag is decoded combinationally from the count, the direction and the enable. In up mode it goes low at the all-ones value, and in down mode at the all-zeros value, but only while the enable is active. Several counters can therefore be chained through the flag.

Internally, a mode decoder names the five operating states: `MODE_CLEAR`, `MODE_PRESET`, `MODE_HOLD`, `MODE_UP` and `MODE_DOWN`. The transition taken on each clock edge follows from the active mode:
- `MODE_UP` moves to count+1.
- `MODE_DOWN` moves to count-1.
- `MODE_HOLD` keeps the count.
- `MODE_CLEAR` and `MODE_PRESET` are applied asynchronously, without waiting for an edge.

Top module: `updown_preset_counter`

## Requirements
- R1: While `mst_clr` is high, `count` is 0 at once. This overrides `pload`, `en_n`, `dir_up` and clock edges.
- R2: While `pload` is high and `mst_clr` is low, `count` follows `pdata` at once, including changes to `pdata`. Clock edges, `en_n` and `dir_up` have no effect.
- R3: With `pload` low, `en_n` low and `dir_up` high, each rising clock edge adds 1 modulo 16, so 15 steps to 0.
- R4: With `pload` low, `en_n` low and `dir_up` low, each rising clock edge subtracts 1 modulo 16, so 0 steps to 15.
- R5: With `en_n` high and both asynchronous controls low, `count` keeps its value across clock edges.
- R6: With `dir_up` high, `term_n` is 0 exactly when `count` is 15 and `en_n` is 0. Otherwise it is 1.
- R7: With `dir_up` low, `term_n` is 0 exactly when `count` is 0 and `en_n` is 0. Otherwise it is 1. `term_n` is combinational and responds to changes of `dir_up` or `en_n` without a clock edge.
- R8: After `mst_clr` or `pload` is released, the first qualifying rising edge steps from the cleared or preset value. No edge is lost and none is doubled.
- R9: A change of `dir_up` while counting takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| mst_clr | input | 1 | Asynchronous clear, active high, highest priority |
| pload | input | 1 | Asynchronous level preset, active high |
| pdata | input | 4 | Preset value |
| en_n | input | 1 | Count enable, active low |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| count | output | 4 | Current count |
| term_n | output | 1 | Terminal flag, active low |

## Verification
The count is the only state. A wrong next-value or a mis-decoded mode therefore shows on `count` after the first rising edge that should have stepped or held. A lost or doubled edge after a preset shows up the same way, at the first edge after release. A broken asynchronous path shows within one time step of the change on `mst_clr`, `pload` or `pdata`, with no clock involved. A faulty terminal decode shows on `term_n` as soon as the count, direction or enable reaches a boundary value, also without a clock edge.

// File: rtl/updown_counter_pkg.sv
package updown_counter_pkg;
    typedef enum logic [2:0] {
        MODE_CLEAR  = 3'd0,
        MODE_PRESET = 3'd1,
        MODE_HOLD   = 3'd2,
        MODE_UP     = 3'd3,
        MODE_DOWN   = 3'd4
    } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
    import updown_counter_pkg::*;
(
    input  logic      mst_clr,
    input  logic      pload,
    input  logic      en_n,
    input  logic      dir_up,
    output cnt_mode_e mode
);
    // Priority: clear, then preset, then enable, then direction.
    always_comb begin
        if (mst_clr)     mode = MODE_CLEAR;
        else if (pload)  mode = MODE_PRESET;
        else if (en_n)   mode = MODE_HOLD;
        else if (dir_up) mode = MODE_UP;
        else             mode = MODE_DOWN;
    end
endmodule

// File: rtl/cnt_step.sv
module cnt_step
    import updown_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_mode_e        mode,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (mode)
            MODE_UP:   nxt = cur + ONE;
            MODE_DOWN: nxt = cur - ONE;
            default:   nxt = cur;   // clear/preset act asynchronously; hold keeps value
        endcase
    end
endmodule

// File: rtl/cnt_bit_cell.sv
module cnt_bit_cell (
    input  logic clk,
    input  logic clr,
    input  logic set,
    input  logic nxt,
    output logic q
);
    // Asynchronous clear has priority over asynchronous set.
    always_ff @(posedge clk or posedge clr or posedge set) begin
        if (clr)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else          q <= nxt;
    end
endmodule

// File: rtl/cnt_term_dec.sv
module cnt_term_dec #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_n,
    input  logic             dir_up,
    output logic             term_n
);
    logic at_top;
    logic at_bottom;

    always_comb begin
        at_top    = &cur;
        at_bottom = ~|cur;
        term_n    = ~(~en_n & (dir_up ? at_top : at_bottom));
    end
endmodule

// File: rtl/updown_preset_counter.sv
module updown_preset_counter
    import updown_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             mst_clr,
    input  logic             pload,
    input  logic [WIDTH-1:0] pdata,
    input  logic             en_n,
    input  logic             dir_up,
    output logic [WIDTH-1:0] count,
    output logic             term_n
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    cnt_mode_e        mode;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] bit_clr;
    logic [WIDTH-1:0] bit_set;

    cnt_mode_dec u_mode (
        .mst_clr (mst_clr),
        .pload   (pload),
        .en_n    (en_n),
        .dir_up  (dir_up),
        .mode    (mode)
    );

    cnt_step #(.WIDTH(WIDTH)) u_step (
        .mode (mode),
        .cur  (count),
        .nxt  (nxt)
    );

    // Each flop gets an asynchronous clear or set derived from the preset data.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bit_clr[i] = mst_clr | (pload & ~pdata[i]);
        assign bit_set[i] = ~mst_clr & pload & pdata[i];

        cnt_bit_cell u_cell (
            .clk (clk),
            .clr (bit_clr[i]),
            .set (bit_set[i]),
            .nxt (nxt[i]),
            .q   (count[i])
        );
    end

    cnt_term_dec #(.WIDTH(WIDTH)) u_term (
        .cur    (count),
        .en_n   (en_n),
        .dir_up (dir_up),
        .term_n (term_n)
    );

    // R1
    clear_zero_chk: assert property (@(posedge clk) mst_clr |-> (count == '0));

    // R2
    preset_follow_chk: assert property (@(posedge clk) disable iff (mst_clr)
        pload |-> (count == pdata));

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (mst_clr || pload)
        (!en_n && dir_up) |=> (count == $past(count) + 1'b1));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (mst_clr || pload)
        (!en_n && !dir_up) |=> (count == $past(count) - 1'b1));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (mst_clr || pload)
        en_n |=> $stable(count));

    // R6
    term_up_chk: assert property (@(posedge clk)
        (dir_up && !en_n && count == ALL_ONES) |-> !term_n);

    // R7
    term_down_chk: assert property (@(posedge clk)
        (!term_n && !dir_up) |-> (count == '0 && !en_n));
endmodule

// File: tb/updown_preset_counter_tb_top.sv
`timescale 1ns/1ps
module updown_preset_counter_tb_top;
    logic       clk = 1'b0;
    logic       mst_clr = 1'b0;
    logic       pload = 1'b0;
    logic [3:0] pdata = 4'd0;
    logic       en_n = 1'b1;
    logic       dir_up = 1'b1;
    logic [3:0] count;
    logic       term_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    updown_preset_counter dut_i (
        .clk     (clk),
        .mst_clr (mst_clr),
        .pload   (pload),
        .pdata   (pdata),
        .en_n    (en_n),
        .dir_up  (dir_up),
        .count   (count),
        .term_n  (term_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Wait for a rising edge, then sample 1 ns later.
    task automatic edge_sample();
        @(posedge clk);
        #1;
    endtask

    task automatic to_negedge();
        @(negedge clk);
    endtask

    // Preset a value across one clock edge, release at a falling edge.
    task automatic preset_to(input logic [3:0] v);
        to_negedge();
        pdata = v;
        pload = 1'b1;
        edge_sample();
        to_negedge();
        pload = 1'b0;
    endtask

    task automatic t_clear();
        mst_clr = 1'b1;
        en_n    = 1'b0;
        #1;
        chk("R1 reset count", count, 0);
        edge_sample();
        chk("R1 clear overrides clock", count, 0);
        chk("R6 term at zero counting up", term_n, 1);
        to_negedge();
        pload = 1'b1;
        pdata = 4'hF;
        #1;
        chk("R1 clear overrides preset", count, 0);
        mst_clr = 1'b0;
        #1;
        chk("R2 preset after clear release", count, 15);
        to_negedge();
        pload = 1'b0;
        en_n  = 1'b1;
    endtask

    task automatic t_preset_with_clock();
        to_negedge();
        en_n   = 1'b0;
        dir_up = 1'b1;
        pdata  = 4'd9;
        pload  = 1'b1;
        #1;
        chk("R2 preset immediate", count, 9);
        for (int k = 0; k < 3; k++) begin
            edge_sample();
            chk("R2 preset ignores clock", count, 9);
        end
        dir_up = 1'b0;
        pdata  = 4'd6;
        #1;
        chk("R2 preset follows data", count, 6);
        edge_sample();
        chk("R2 preset ignores direction", count, 6);
        to_negedge();
        pload  = 1'b0;
        dir_up = 1'b1;
        edge_sample();
        chk("R8 first edge after preset", count, 7);
        edge_sample();
        chk("R8 second edge after preset", count, 8);
        to_negedge();
        en_n = 1'b1;
    endtask

    task automatic t_count_up_wrap();
        dir_up = 1'b1;
        preset_to(4'd13);
        en_n = 1'b0;
        edge_sample();
        chk("R3 up 13->14", count, 14);
        edge_sample();
        chk("R3 up 14->15", count, 15);
        chk("R6 term low at 15", term_n, 0);
        edge_sample();
        chk("R3 up wrap 15->0", count, 0);
        chk("R6 term high at 0 up", term_n, 1);
        edge_sample();
        chk("R3 up 0->1", count, 1);
        to_negedge();
        en_n = 1'b1;
    endtask

    task automatic t_count_down_wrap();
        dir_up = 1'b0;
        preset_to(4'd2);
        en_n = 1'b0;
        edge_sample();
        chk("R4 down 2->1", count, 1);
        edge_sample();
        chk("R4 down 1->0", count, 0);
        chk("R7 term low at 0", term_n, 0);
        edge_sample();
        chk("R4 down wrap 0->15", count, 15);
        chk("R7 term high at 15 down", term_n, 1);
        to_negedge();
        en_n = 1'b1;
    endtask

    task automatic t_hold();
        dir_up = 1'b1;
        preset_to(4'd15);
        #1;
        chk("R6 term high while disabled", term_n, 1);
        for (int k = 0; k < 3; k++) begin
            edge_sample();
            chk("R5 hold", count, 15);
        end
        to_negedge();
        en_n = 1'b0;
        #1;
        chk("R6 term follows enable", term_n, 0);
        to_negedge();
        en_n = 1'b1;
    endtask

    task automatic t_direction_change();
        dir_up = 1'b1;
        preset_to(4'd0);
        en_n = 1'b0;
        #1;
        chk("R6 term high at 0 up", term_n, 1);
        dir_up = 1'b0;
        #1;
        chk("R7 term reacts to direction", term_n, 0);
        edge_sample();
        chk("R9 direction at next edge", count, 15);
        to_negedge();
        dir_up = 1'b1;
        edge_sample();
        chk("R9 back to up", count, 0);
        to_negedge();
        mst_clr = 1'b1;
        edge_sample();
        chk("R1 clear while counting", count, 0);
        to_negedge();
        mst_clr = 1'b0;
        edge_sample();
        chk("R8 first edge after clear", count, 1);
        to_negedge();
        en_n = 1'b1;
    endtask

    initial begin
        #1;
        t_clear();
        t_preset_with_clock();
        t_count_up_wrap();
        t_count_down_wrap();
        t_hold();
        t_direction_change();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule